// File: doc/BRIEF.md
# Serial TDM Time-Slot Interchanger

This block moves bytes between the channels of up to eight serial time-division streams that share an 8 kHz frame. Every input stream is deserialized and each received byte is stored in a two-page data store. A per-output connection table tells each output time slot what to send: the byte that arrived in a chosen source channel during the previous frame, a fixed byte written by the controlling processor, or nothing at all, with the line left undriven.

The line rate is picked by a two-bit field. The rate sets how many channels each stream carries and how many streams are in use, so the total stays at 512 channels or fewer. One bit clock of `clk` carries one serial bit on every line. A frame pulse of selectable polarity marks the first bit of a frame. Without pulses, the frame counter wraps after one frame length. The controlling processor writes connection entries through a simple write port. Through a combinational read port it can look at any input channel from the last completed frame.

Top module: `tsi_serial_switch`

## Requirements
- R1: After reset every connection entry is in float mode, so no output line is driven (`ser_oe` all zero and `ser_out` all zero).
- R2: `rate_sel` 0 gives 8 streams of 32 channels (frame of 256 bit clocks). 1 gives 8 streams of 64 channels (512 bit clocks). 2 or 3 gives 4 streams of 128 channels (1024 bit clocks). At the 128-channel rate, lines 4 to 7 are never driven and their inputs are ignored.
- R3: An active frame pulse marks the bit clock that carries bit 7 of channel 0. Bits follow most significant first, eight bit clocks per channel. With no pulse, the next frame starts right after the last bit clock of the current one.
- R4: A channel address is 9 bits. At 32 channels it is {0, stream[2:0], channel[4:0]}. At 64 channels it is {stream[2:0], channel[5:0]}. At 128 channels it is {stream[1:0], channel[6:0]}. Output slots and sources both use this packing.
- R5: An output slot in switch mode (code 01) drives the byte received at its source address during the previous frame. The delay is exactly one frame for every channel.
- R6: An output slot in message mode (code 10) drives the byte stored in its own entry, MSB first.
- R7: An output slot with mode code 00 or 11 leaves its line undriven (`ser_oe` low, `ser_out` low) for that slot only.
- R8: `mon_data` returns the byte received at `mon_addr` during the most recently completed frame.
- R9: With `fp_high` set, a high level on `frame_in` is the pulse. With it clear, a low level is the pulse.
- R10: A write on `cm_wr` stores {`cm_mode`, `cm_msg`, `cm_src`} at `cm_addr` and governs that output slot from the next bit clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_in | input | 1 | Frame pulse |
| fp_high | input | 1 | Frame pulse polarity: 1 active high, 0 active low |
| rate_sel | input | 2 | Line rate: 0 = 32 ch, 1 = 64 ch, 2/3 = 128 ch |
| ser_in | input | 8 | Serial input lines, one per stream |
| ser_out | output | 8 | Serial output data, one per stream |
| ser_oe | output | 8 | Output drive enable, one per stream |
| cm_wr | input | 1 | Connection entry write strobe |
| cm_addr | input | 9 | Output slot address of the entry (R4 packing) |
| cm_mode | input | 2 | Entry mode: 00 float, 01 switch, 10 message, 11 float |
| cm_src | input | 9 | Source channel address (R4 packing) |
| cm_msg | input | 8 | Message byte |
| mon_addr | input | 9 | Input channel address to read (R4 packing) |
| mon_data | output | 8 | Byte received at `mon_addr` in the last completed frame |

## Verification
The bench loads random connection maps at all three channel counts and compares every output line in every bit clock against a model that uses the previous frame's input bytes. A design that read the page currently being written would show the current frame's bytes, or a mix of frames, in place of the older frame. A wrong address split per rate would pull bytes from the wrong stream. A bit-order slip would shift every byte. Message and float slots are interleaved with switched ones, so an enable that lags or leaks into a neighbouring slot shows up at once. Runs with both pulse polarities, and a run that gets only its first pulse, catch a frame counter that misreads the pulse or does not wrap on its own.

// File: rtl/tsi_pkg.sv
// Shared widths, types and address helpers for the serial time-slot interchanger.
// Assumes one serial bit per clock and at most 512 channels per frame.
package tsi_pkg;
    localparam int N_STREAMS = 8;
    localparam int STRM_W    = 3;
    localparam int CHAN_W    = 7;
    localparam int ADDR_W    = 9;
    localparam int POS_W     = 10;
    localparam int BYTE_W    = 8;

    typedef enum logic [1:0] {
        CM_FLOAT     = 2'b00,
        CM_SWITCH    = 2'b01,
        CM_MESSAGE   = 2'b10,
        CM_FLOAT_ALT = 2'b11
    } cm_mode_e;

    typedef struct packed {
        cm_mode_e           mode;
        logic [BYTE_W-1:0]  msg;
        logic [ADDR_W-1:0]  src;
    } cm_entry_t;

    // Packs stream and channel into one address; the split depends on the rate.
    function automatic logic [ADDR_W-1:0] pack_addr(input logic [1:0] rate,
                                                    input logic [STRM_W-1:0] strm,
                                                    input logic [CHAN_W-1:0] chan);
        case (rate)
            2'd0:    pack_addr = {1'b0, strm, chan[4:0]};
            2'd1:    pack_addr = {strm, chan[5:0]};
            default: pack_addr = {strm[1:0], chan};
        endcase
    endfunction

    // Last bit position of a frame for the selected rate.
    function automatic logic [POS_W-1:0] frame_last(input logic [1:0] rate);
        case (rate)
            2'd0:    frame_last = POS_W'(255);
            2'd1:    frame_last = POS_W'(511);
            default: frame_last = POS_W'(1023);
        endcase
    endfunction

    // Number of streams in use at the selected rate.
    function automatic int active_streams(input logic [1:0] rate);
        active_streams = (rate >= 2'd2) ? N_STREAMS / 2 : N_STREAMS;
    endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
// Frame timer: tracks the bit position inside the frame and the data page being
// written. An active frame pulse forces position 0. Without a pulse the counter
// wraps after the last bit of the frame. The page flips at every position 0.
// Assumes the pulse, if present, lasts one bit clock.
module tsi_frame_timer
    import tsi_pkg::*;
#(
    parameter int P_W = POS_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_in,
    input  logic           fp_high,
    input  logic [1:0]     rate,
    output logic [P_W-1:0] pos,
    output logic           page
);
    logic [P_W-1:0] cnt_q;
    logic           page_q;
    logic           fp_act;

    // Decode the pulse level and work out this cycle's position and page.
    always_comb begin
        fp_act = fp_high ? frame_in : ~frame_in;
        if (fp_act || (cnt_q >= P_W'(frame_last(rate))))
            pos = '0;
        else
            pos = cnt_q + 1'b1;
        page = (pos == '0) ? ~page_q : page_q;
    end

    // Hold the position and page for the next bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '1;
            page_q <= 1'b0;
        end else begin
            cnt_q  <= pos;
            page_q <= page;
        end
    end

    p_frame_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fp_act |=> (cnt_q == '0));

    p_page_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> (page_q != $past(page_q)));
endmodule

// File: rtl/tsi_data_store.sv
// Data store: one shift register per stream deserializes each input line. At
// the last bit of each channel the byte goes into the write page of a two-page
// memory. Reads always come from the other page, which holds the previous frame.
// Assumes pos and page come from the frame timer.
module tsi_data_store
    import tsi_pkg::*;
#(
    parameter int NS  = N_STREAMS,
    parameter int AW  = ADDR_W,
    parameter int P_W = POS_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             rate,
    input  logic [P_W-1:0]         pos,
    input  logic                   page,
    input  logic [NS-1:0]          ser_in,
    input  logic [NS-1:0][AW-1:0]  rd_addr,
    input  logic [AW-1:0]          mon_addr,
    output logic [NS-1:0][7:0]     rd_data,
    output logic [7:0]             mon_data
);
    localparam int DEPTH = 1 << AW;

    logic [6:0]  sh_q  [NS];
    logic [7:0]  mem_q [0:1][0:DEPTH-1];
    logic [CHAN_W-1:0] chan;
    logic        wr_slot;
    logic        rd_page;

    // Channel number, byte-complete flag and read page for this bit clock.
    always_comb begin
        chan    = CHAN_W'(pos >> 3);
        wr_slot = (pos[2:0] == 3'd7);
        rd_page = ~page;
    end

    // Shift each input line into its own register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) sh_q[s] <= '0;
        end else begin
            for (int s = 0; s < NS; s++) sh_q[s] <= {sh_q[s][5:0], ser_in[s]};
        end
    end

    // Store each completed byte of an active stream into the write page.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NS; s++) begin
            if (wr_slot && (s < active_streams(rate)))
                mem_q[page][pack_addr(rate, STRM_W'(s), chan)] <= {sh_q[s], ser_in[s]};
        end
    end

    // Read switched bytes and the monitor byte from the completed page.
    always_comb begin
        for (int s = 0; s < NS; s++) rd_data[s] = mem_q[rd_page][rd_addr[s]];
        mon_data = mem_q[rd_page][mon_addr];
    end

    p_page_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pos != '0) |-> (page == $past(page)));
endmodule

// File: rtl/tsi_conn_mem.sv
// Connection memory: one entry per output slot holding mode, message byte and
// source address. It is written one entry per clock and read by every stream at
// once. Reset puts every entry into float mode.
module tsi_conn_mem
    import tsi_pkg::*;
#(
    parameter int NS = N_STREAMS,
    parameter int AW = ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [AW-1:0]         wr_addr,
    input  cm_entry_t             wr_entry,
    input  logic [NS-1:0][AW-1:0] rd_addr,
    output cm_entry_t [NS-1:0]    rd_entry
);
    localparam int DEPTH = 1 << AW;

    cm_entry_t mem_q [0:DEPTH-1];

    // Clear the table on reset and take processor writes afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i].mode <= CM_FLOAT;
                mem_q[i].msg  <= '0;
                mem_q[i].src  <= '0;
            end
        end else if (wr) begin
            mem_q[wr_addr] <= wr_entry;
        end
    end

    // Look up the entry for each stream's current output slot.
    always_comb begin
        for (int s = 0; s < NS; s++) rd_entry[s] = mem_q[rd_addr[s]];
    end

    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (mem_q[$past(wr_addr)] == $past(wr_entry)));
endmodule

// File: rtl/tsi_serial_switch.sv
// Serial time-slot interchanger top. Ties the frame timer, the two-page data
// store and the connection memory together, and rebuilds each output line bit by
// bit from the entry of the current output slot. Outputs are combinational from
// registered state and the frame pulse. Assumes the pulse is one bit clock wide.
module tsi_serial_switch
    import tsi_pkg::*;
#(
    parameter int NS  = N_STREAMS,
    parameter int AW  = ADDR_W,
    parameter int P_W = POS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_in,
    input  logic          fp_high,
    input  logic [1:0]    rate_sel,
    input  logic [NS-1:0] ser_in,
    output logic [NS-1:0] ser_out,
    output logic [NS-1:0] ser_oe,
    input  logic          cm_wr,
    input  logic [AW-1:0] cm_addr,
    input  logic [1:0]    cm_mode,
    input  logic [AW-1:0] cm_src,
    input  logic [7:0]    cm_msg,
    input  logic [AW-1:0] mon_addr,
    output logic [7:0]    mon_data
);
    logic [P_W-1:0]        pos;
    logic                  page;
    logic [CHAN_W-1:0]     chan;
    logic [2:0]            bit_sel;
    logic [NS-1:0][AW-1:0] slot_addr;
    logic [NS-1:0][AW-1:0] src_addr;
    logic [NS-1:0][7:0]    sw_byte;
    cm_entry_t [NS-1:0]    entry;
    cm_entry_t             wr_entry;

    // Slot coordinates and the entry to be written.
    always_comb begin
        chan           = CHAN_W'(pos >> 3);
        bit_sel        = 3'd7 - pos[2:0];
        wr_entry.mode  = cm_mode_e'(cm_mode);
        wr_entry.msg   = cm_msg;
        wr_entry.src   = cm_src;
    end

    tsi_frame_timer #(.P_W(P_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_in (frame_in),
        .fp_high  (fp_high),
        .rate     (rate_sel),
        .pos      (pos),
        .page     (page)
    );

    tsi_conn_mem #(.NS(NS), .AW(AW)) u_cmem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cm_wr),
        .wr_addr  (cm_addr),
        .wr_entry (wr_entry),
        .rd_addr  (slot_addr),
        .rd_entry (entry)
    );

    tsi_data_store #(.NS(NS), .AW(AW), .P_W(P_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate     (rate_sel),
        .pos      (pos),
        .page     (page),
        .ser_in   (ser_in),
        .rd_addr  (src_addr),
        .mon_addr (mon_addr),
        .rd_data  (sw_byte),
        .mon_data (mon_data)
    );

    for (genvar s = 0; s < NS; s++) begin : g_line
        logic active;
        // Pick the slot address, source and driven bit for this output line.
        always_comb begin
            active       = (s < active_streams(rate_sel));
            slot_addr[s] = pack_addr(rate_sel, STRM_W'(s), chan);
            src_addr[s]  = entry[s].src;
            ser_oe[s]    = 1'b0;
            ser_out[s]   = 1'b0;
            if (active) begin
                case (entry[s].mode)
                    CM_SWITCH: begin
                        ser_oe[s]  = 1'b1;
                        ser_out[s] = sw_byte[s][bit_sel];
                    end
                    CM_MESSAGE: begin
                        ser_oe[s]  = 1'b1;
                        ser_out[s] = entry[s].msg[bit_sel];
                    end
                    default: begin
                        ser_oe[s]  = 1'b0;
                        ser_out[s] = 1'b0;
                    end
                endcase
            end
        end
    end

    p_idle_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (ser_oe == '0));

    p_quiet_streams_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel >= 2'd2) |-> (ser_oe[NS-1:NS/2] == '0));

    p_oe_needs_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_oe[0] |-> ((entry[0].mode == CM_SWITCH) || (entry[0].mode == CM_MESSAGE)));
endmodule

// File: tb/tsi_serial_switch_bench.sv
// Scoreboard bench: the driver pushes the expected {oe, out} word of each bit
// clock into a queue, and the monitor pops and compares it later in that cycle.
module tsi_serial_switch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_in = 1'b1;
    logic       fp_high = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic [7:0] ser_in = '0;
    logic [7:0] ser_out, ser_oe;
    logic       cm_wr = 1'b0;
    logic [8:0] cm_addr = '0;
    logic [1:0] cm_mode = '0;
    logic [8:0] cm_src = '0;
    logic [7:0] cm_msg = '0;
    logic [8:0] mon_addr = '0;
    logic [7:0] mon_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [15:0] q_exp[$];
    string       q_tag[$];

    logic [7:0] prv [512];
    logic [7:0] cur [512];
    logic [1:0] m_mode [512];
    logic [8:0] m_src [512];
    logic [7:0] m_msg [512];

    always #4 clk = ~clk;

    tsi_serial_switch u_tsi_serial_switch (
        .clk(clk), .rst_n(rst_n), .frame_in(frame_in), .fp_high(fp_high),
        .rate_sel(rate_sel), .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe),
        .cm_wr(cm_wr), .cm_addr(cm_addr), .cm_mode(cm_mode), .cm_src(cm_src),
        .cm_msg(cm_msg), .mon_addr(mon_addr), .mon_data(mon_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic int nact(input logic [1:0] rt);
        return (rt >= 2) ? 4 : 8;
    endfunction

    function automatic int cpf(input logic [1:0] rt);
        return (rt == 0) ? 32 : (rt == 1) ? 64 : 128;
    endfunction

    function automatic int addr_of(input logic [1:0] rt, input int s, input int ch);
        return s * cpf(rt) + ch;
    endfunction

    // Monitor: pop one expected word per cycle and compare with the lines.
    always @(negedge clk) begin
        logic [15:0] e;
        string t;
        #3;
        if (q_exp.size() > 0) begin
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check({ser_oe, ser_out} === e, t, 32'({ser_oe, ser_out}), 32'(e));
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d cycles expected=finished", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // R10: load a random connection map, one entry per cycle.
    task automatic program_map(input logic [1:0] rt);
        for (int a = 0; a < 512; a++) begin
            int r = $urandom % 100;
            logic [1:0] md = (r < 65) ? 2'b01 : (r < 80) ? 2'b10 : (r < 92) ? 2'b00 : 2'b11;
            m_mode[a] = md;
            m_src[a]  = 9'((rt == 0) ? ($urandom % 256) : ($urandom % 512));
            m_msg[a]  = 8'($urandom);
            @(negedge clk);
            cm_wr = 1'b1; cm_addr = 9'(a); cm_mode = md; cm_src = m_src[a]; cm_msg = m_msg[a];
        end
        @(negedge clk);
        cm_wr = 1'b0;
    endtask

    // Drive one frame; when chk is set, push the expected output of every cycle.
    task automatic run_frame(input logic [1:0] rt, input bit pulse, input bit chk,
                             input string tag);
        int flen = 256 * (cpf(rt) / 32);
        for (int a = 0; a < 512; a++) cur[a] = 8'($urandom);
        for (int p = 0; p < flen; p++) begin
            logic [7:0] eo, ed;
            int ch = p / 8;
            int b  = 7 - (p % 8);
            @(negedge clk);
            frame_in = (p == 0 && pulse) ? fp_high : ~fp_high;
            eo = '0; ed = '0;
            for (int s = 0; s < 8; s++) begin
                if (s < nact(rt)) begin
                    int a = addr_of(rt, s, ch);
                    ser_in[s] = cur[a][b];
                    if (m_mode[a] == 2'b01) begin
                        eo[s] = 1'b1; ed[s] = prv[m_src[a]][b];
                    end else if (m_mode[a] == 2'b10) begin
                        eo[s] = 1'b1; ed[s] = m_msg[a][b];
                    end
                end else begin
                    ser_in[s] = 1'($urandom);
                end
            end
            if (chk) begin
                q_exp.push_back({eo, ed});
                q_tag.push_back(tag);
            end
        end
        for (int a = 0; a < 512; a++) prv[a] = cur[a];
    endtask

    // R8: read back input channels of the frame just completed.
    task automatic mon_checks(input logic [1:0] rt);
        @(negedge clk);
        frame_in = ~fp_high;
        ser_in = '0;
        for (int k = 0; k < 8; k++) begin
            int a = (rt == 0) ? int'($urandom % 256) : int'($urandom % 512);
            if (k == 7) a = (rt == 0) ? 255 : 511;
            mon_addr = 9'(a);
            #3;
            check(mon_data === prv[a], "R8 monitor read", 32'(mon_data), 32'(prv[a]));
            @(negedge clk);
        end
    endtask

    task automatic run_set(input logic [1:0] rt, input bit every_pulse, input string tag);
        @(negedge clk);
        rate_sel = rt;
        frame_in = ~fp_high;
        program_map(rt);
        run_frame(rt, 1'b1, 1'b0, tag);
        run_frame(rt, every_pulse, 1'b1, tag);
        run_frame(rt, every_pulse, 1'b1, tag);
        mon_checks(rt);
    endtask

    initial begin
        for (int a = 0; a < 512; a++) prv[a] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: nothing driven after reset.
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            q_exp.push_back(16'h0000);
            q_tag.push_back("R1 idle after reset");
        end
        // R9 active-low pulse, R5 R6 R7 R4 at 32 channels.
        fp_high = 1'b0;
        run_set(2'd0, 1'b1, "R5/R6/R7/R4/R9 32ch low pulse");
        // R9 active-high pulse at 32 channels.
        @(negedge clk);
        fp_high = 1'b1;
        frame_in = 1'b0;
        run_set(2'd0, 1'b1, "R5/R6/R7/R9 32ch high pulse");
        // R3: free-running frames after a single pulse, 64 channels.
        run_set(2'd1, 1'b0, "R3/R4/R5 64ch free-run");
        // R2: four streams of 128 channels, upper lines quiet.
        run_set(2'd2, 1'b1, "R2/R4/R5 128ch");
        // R2: code 3 behaves as 128 channels.
        run_set(2'd3, 1'b1, "R2 code3 128ch");
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule